// File: doc/BRIEF.md
# Pulse-Coded Isolator Channel Link

This block is a single-channel digital model of a transformer-coupled isolation data path. A transmit-side encoder watches a logic input, and each change becomes a one-cycle event on one of two link lines. A high-going change is sent on the set line and a low-going change on the clear line. While the input stays still, the encoder repeats the event that matches the present level at a fixed cadence, so the far side never loses the DC level.

The receive side is a bistable latch. A watchdog guards it and drops the output to a safe low level when the link goes silent. The analog coupling and the supply comparators are not modelled. Each side's supply status enters as a digital "power good" flag. When the transmit flag is low, the link falls silent. When the receive flag is low, the output is forced low.

The link lines are brought out as ports so the pulse traffic can be observed. All timing is in clock cycles. `REFRESH_CYC` and `WDOG_CYC` default to 1 µs and 5 µs at a 50 MHz clock.

Top module: `isolink_chan`

## Requirements
- R1: The input passes through a two-flop synchronizer. A low-to-high input change produces exactly one `lnk_set` pulse, one cycle wide, three clock edges after the change. A high-to-low change produces one `lnk_clr` pulse in the same way. The two lines are never high together.
- R2: `dout` goes high on the edge after a `lnk_set` pulse and low on the edge after a `lnk_clr` pulse. It holds its value between pulses. The total latency from `din` to `dout` is four clock edges.
- R3: While the input is idle and the transmit supply is good, the encoder repeats the pulse for the current level every `REFRESH_CYC` cycles. The count starts from the last pulse of any cause, so an edge that coincides with a refresh slot sends only the edge pulse and restarts the count.
- R4: While reset is asserted, `dout`, `lnk_set` and `lnk_clr` are low. The receive watchdog leaves reset in the expired state.
- R5: If no pulse of either kind arrives for `WDOG_CYC` cycles, `dout` is forced low. The next pulse received restores normal tracking.
- R6: While `tx_pwr_ok` is low, no pulse is sent. `dout` keeps its last value until the watchdog expires, and then goes low.
- R7: When `tx_pwr_ok` returns high, the encoder sends the pulse for the current level on the very next edge. `dout` follows the input two edges after the flag rises.
- R8: While `rx_pwr_ok` is low, `dout` is low regardless of the input. The latch keeps tracking pulses during this time. When the flag returns, `dout` shows the latched level on the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 1 | Logic input to be carried across the link |
| tx_pwr_ok | input | 1 | Transmit-side supply good |
| rx_pwr_ok | input | 1 | Receive-side supply good |
| dout | output | 1 | Isolated output level |
| lnk_set | output | 1 | Link set pulse (observation) |
| lnk_clr | output | 1 | Link clear pulse (observation) |

## Verification
The bench builds the block with `REFRESH_CYC` = 8 and `WDOG_CYC` = 40. With these values, a refresh period and a full watchdog expiry fit into a few dozen cycles, so exact-cycle checks of both intervals and many lockout and recovery sequences fit in one short run. Random input toggles, some faster than the latency and some idle stretches of several refresh periods, are compared against the expected level once each hold exceeds the four-edge latency.

// File: rtl/isolink_pkg.sv
package isolink_pkg;
  // One link event: at most one of the two lines is high in a cycle.
  typedef struct packed {
    logic set;
    logic clr;
  } lnk_pulse_t;
endpackage

// File: rtl/isolink_enc.sv
module isolink_enc
  import isolink_pkg::*;
#(
  parameter int unsigned REFRESH_CYC = 50,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic       pwr_ok,
  output lnk_pulse_t pulse_o
);
  localparam int unsigned CW = (REFRESH_CYC > 2) ? $clog2(REFRESH_CYC) : 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   lvl_q;
  logic                   ok_q;
  logic [CW-1:0]          cnt_q, cnt_d;
  lnk_pulse_t             pls_q, pls_d;

  logic lvl, edge_hit, refresh_hit, announce, fire;

  // next-state logic
  always_comb begin
    sync_d      = {sync_q[SYNC_STAGES-2:0], din};
    lvl         = sync_q[SYNC_STAGES-1];
    edge_hit    = lvl ^ lvl_q;
    refresh_hit = (cnt_q == CW'(REFRESH_CYC - 1));
    announce    = pwr_ok & ~ok_q;
    fire        = edge_hit | refresh_hit | announce;
    pls_d.set   = pwr_ok & fire & lvl;
    pls_d.clr   = pwr_ok & fire & ~lvl;
    if (fire || !pwr_ok) cnt_d = '0;
    else                 cnt_d = cnt_q + CW'(1);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      lvl_q  <= 1'b0;
      ok_q   <= 1'b0;
      cnt_q  <= '0;
      pls_q  <= '0;
    end else begin
      sync_q <= sync_d;
      lvl_q  <= lvl;
      ok_q   <= pwr_ok;
      cnt_q  <= cnt_d;
      pls_q  <= pls_d;
    end
  end

  assign pulse_o = pls_q;

  // R1
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pls_q.set && pls_q.clr));
  // R1
  set_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pls_q.set |=> !pls_q.set);
  // R1
  clr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pls_q.clr |=> !pls_q.clr);
  // R6
  tx_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (pls_q == '0));
endmodule

// File: rtl/isolink_dec.sv
module isolink_dec
  import isolink_pkg::*;
#(
  parameter int unsigned WDOG_CYC = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  lnk_pulse_t pulse_i,
  output logic       level_o
);
  localparam int unsigned WW = (WDOG_CYC > 2) ? $clog2(WDOG_CYC) : 1;

  logic          q_q, q_d;
  logic          exp_q, exp_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          got;

  // next-state logic: a clear beats a set in the same cycle
  always_comb begin
    got    = pulse_i.set | pulse_i.clr;
    q_d    = q_q;
    exp_d  = exp_q;
    wcnt_d = wcnt_q;
    if (got) begin
      q_d    = ~pulse_i.clr;
      exp_d  = 1'b0;
      wcnt_d = '0;
    end else if (!exp_q) begin
      if (wcnt_q == WW'(WDOG_CYC - 1)) begin
        exp_d = 1'b1;
        q_d   = 1'b0;
      end else begin
        wcnt_d = wcnt_q + WW'(1);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= 1'b0;
      exp_q  <= 1'b1;
      wcnt_q <= '0;
    end else begin
      q_q    <= q_d;
      exp_q  <= exp_d;
      wcnt_q <= wcnt_d;
    end
  end

  assign level_o = q_q;

  // R2
  set_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_i.set && !pulse_i.clr) |=> q_q);
  // R2
  clr_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_i.clr |=> !q_q);
  // R5
  wdog_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |-> !q_q);
endmodule

// File: rtl/isolink_chan.sv
module isolink_chan
  import isolink_pkg::*;
#(
  parameter int unsigned REFRESH_CYC = 50,
  parameter int unsigned WDOG_CYC    = 250,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic tx_pwr_ok,
  input  logic rx_pwr_ok,
  output logic dout,
  output logic lnk_set,
  output logic lnk_clr
);
  logic [1:0] rs_q;
  logic       rst_int_n;
  lnk_pulse_t link;
  logic       rx_level;

  // reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  isolink_enc #(
    .REFRESH_CYC (REFRESH_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_enc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .din     (din),
    .pwr_ok  (tx_pwr_ok),
    .pulse_o (link)
  );

  isolink_dec #(
    .WDOG_CYC (WDOG_CYC)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .pulse_i (link),
    .level_o (rx_level)
  );

  assign dout    = rx_level & rx_pwr_ok;
  assign lnk_set = link.set;
  assign lnk_clr = link.clr;

  // R2, R8
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(dout) |-> ($past(link.set) || $rose(rx_pwr_ok)));
  // R4
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_int_n |-> (!dout || !rx_pwr_ok) && !lnk_set && !lnk_clr);
endmodule

// File: tb/sim_isolink_chan.sv
module sim_isolink_chan;
  localparam int RC = 8;
  localparam int WC = 40;

  logic clk = 1'b0;
  logic rst_n, din, tx_ok, rx_ok;
  logic dout, lnk_set, lnk_clr;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #10 clk = ~clk;

  isolink_chan #(.REFRESH_CYC(RC), .WDOG_CYC(WC), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .tx_pwr_ok(tx_ok), .rx_pwr_ok(rx_ok),
    .dout(dout), .lnk_set(lnk_set), .lnk_clr(lnk_clr));

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic       d;
    logic       tx;
    logic       rx;
    logic [7:0] hold;
    logic       exp;
  } vec_t;

  localparam vec_t VEC [0:14] = '{
    '{1'b1, 1'b1, 1'b1, 8'd20, 1'b1},
    '{1'b0, 1'b1, 1'b1, 8'd20, 1'b0},
    '{1'b1, 1'b1, 1'b1, 8'd30, 1'b1},
    '{1'b1, 1'b0, 1'b1, 8'd60, 1'b0},
    '{1'b1, 1'b1, 1'b1, 8'd10, 1'b1},
    '{1'b1, 1'b1, 1'b0, 8'd10, 1'b0},
    '{1'b0, 1'b1, 1'b0, 8'd10, 1'b0},
    '{1'b0, 1'b1, 1'b1, 8'd10, 1'b0},
    '{1'b1, 1'b1, 1'b1, 8'd10, 1'b1},
    '{1'b0, 1'b0, 1'b1, 8'd5,  1'b1},
    '{1'b0, 1'b0, 1'b1, 8'd60, 1'b0},
    '{1'b0, 1'b1, 1'b1, 8'd10, 1'b0},
    '{1'b1, 1'b1, 1'b1, 8'd6,  1'b1},
    '{1'b1, 1'b1, 1'b0, 8'd10, 1'b0},
    '{1'b1, 1'b1, 1'b1, 8'd1,  1'b1}
  };
  string vtag [0:14] = '{"R2", "R2", "R3", "R5 R6", "R7", "R8", "R8", "R8",
                         "R2", "R6", "R6", "R7", "R2", "R8", "R8"};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired before the run ended");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    rst_n = 1'b0; din = 1'b1; tx_ok = 1'b1; rx_ok = 1'b1;
    // R4: quiet during reset
    step(3);
    chk(dout, 1'b0, "R4 dout in reset");
    chk(lnk_set | lnk_clr, 1'b0, "R4 link quiet in reset");
    rst_n = 1'b1;
    step(10);
    chk(dout, 1'b1, "R4 tracks input after reset");

    // table walk
    for (int i = 0; i <= 14; i++) begin
      din = VEC[i].d; tx_ok = VEC[i].tx; rx_ok = VEC[i].rx;
      step(int'(VEC[i].hold));
      chk(dout, VEC[i].exp, $sformatf("%s table row %0d", vtag[i], i));
    end

    // R1 R2 R3: rising edge timing and refresh spacing
    din = 1'b0; step(20);
    din = 1'b1;
    step(2); chk(lnk_set, 1'b0, "R1 no set before sync delay");
    step(1); chk(lnk_set, 1'b1, "R1 set pulse at third edge");
    chk(dout, 1'b0, "R2 dout not yet updated");
    step(1); chk(lnk_set, 1'b0, "R1 set pulse one cycle");
    chk(dout, 1'b1, "R2 dout high after set");
    step(RC - 2); chk(lnk_set, 1'b0, "R3 no early refresh");
    step(1); chk(lnk_set, 1'b1, "R3 refresh after interval");
    chk(lnk_clr, 1'b0, "R3 refresh matches level");
    // falling edge
    din = 1'b0;
    step(3); chk(lnk_clr, 1'b1, "R1 clr pulse at third edge");
    chk(lnk_set, 1'b0, "R1 lines exclusive");
    step(1); chk(dout, 1'b0, "R2 dout low after clr");

    // R5 R6: watchdog expiry at exact cycle
    din = 1'b1; step(10);
    for (int k = 0; k < 3 * RC && !lnk_set; k++) step(1);
    tx_ok = 1'b0;
    cnt = 0;
    for (int k = 0; k < WC; k++) begin
      step(1);
      if (lnk_set || lnk_clr) cnt++;
    end
    chk(cnt != 0, 1'b0, "R6 no pulse while tx in lockout");
    chk(dout, 1'b1, "R5 held until watchdog interval");
    step(1); chk(dout, 1'b0, "R5 forced low on expiry");

    // R7: immediate announce on supply return
    tx_ok = 1'b1;
    step(1); chk(lnk_set, 1'b1, "R7 announce pulse");
    chk(dout, 1'b0, "R7 dout one edge later");
    step(1); chk(dout, 1'b1, "R7 dout restored");

    // R8: receive lockout gating
    rx_ok = 1'b0;
    step(1); chk(dout, 1'b0, "R8 gated low");
    rx_ok = 1'b1;
    step(1); chk(dout, 1'b1, "R8 level back on return");

    // R2: random toggles and idle stretches
    for (int k = 0; k < 200; k++) begin
      int h;
      h = ((k % 11) == 0) ? 3 * RC : int'($urandom_range(1, 12));
      din = ~din;
      step(h);
      if (h >= 5) chk(dout, din, $sformatf("R2 random step %0d", k));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule